// File: doc/BRIEF.md
# I/O-to-Memory Block Input Engine

This engine copies bytes from an I/O port into memory, the way a compact CPU string-input instruction does. A start command loads a byte counter, an 8-bit port pointer and a memory pointer. It also selects single or repeating operation, a width-override flag, and either 24-bit or 16-bit memory addressing. For each byte, the engine reads from the port on an I/O read strobe. In the next cycle it writes that byte to memory at the address the memory pointer gives. It then steps both pointers up, steps the counter down, and updates a zero flag and a sign-like flag.

In single mode exactly one byte moves. In repeat mode the engine keeps looping until the counter reaches zero. A counter of zero at start therefore moves 256 bytes. Prefix decoding happens outside the block: the override flag only lengthens the setup phase by one cycle. In 16-bit addressing, the memory pointer's low half wraps on its own. The top address byte then comes from a base input.

Top module: `blkin_engine`

## Requirements
- R1: While `io_rd_o` is high, `io_addr_o[7:0]` equals the current port pointer and `io_addr_o[15:8]` is zero.
- R2: Each byte takes three cycles: a read cycle (`io_rd_o`), then a write cycle (`mem_wr_o`) that carries the byte sampled on `io_data_i` during the read cycle, then an update cycle. `io_rd_o` and `mem_wr_o` are never high together.
- R3: After each byte, `cnt_o` drops by one (mod 256), `port_o` rises by one (mod 256) and the memory pointer `ptr_o` rises by one.
- R4: After each byte, `z_o` is 1 exactly when the counter value before the decrement was 1.
- R5: After each byte, `n_o` equals bit 7 of the transferred byte.
- R6: With `repeat_i`=0 exactly one byte moves. With `repeat_i`=1, `cnt_i` bytes move, and `cnt_i`=0 moves 256 bytes and leaves the counter at 0.
- R7: `busy_o` stays high for 2+3*n cycles when `ovr_i`=0, and for 3+3*n cycles when `ovr_i`=1, where n is the number of bytes moved.
- R8: With `wide_i`=0, the memory address is {`base_i`, `ptr_o[15:0]`}. Only `ptr_o[15:0]` increments, wrapping mod 2^16, and `ptr_o[23:16]` keeps its start value.
- R9: With `wide_i`=1, the memory address is `ptr_o` and the pointer wraps mod 2^24.
- R10: `done_o` is high for exactly one cycle, the first cycle after `busy_o` falls. A `start_i` pulse while busy has no effect on the transfer, its results or its timing.
- R11: After reset, `busy_o`, `done_o`, `io_rd_o`, `mem_wr_o`, `z_o` and `n_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start command, taken only when idle |
| repeat_i | input | 1 | 1 = loop until counter is zero, 0 = one byte |
| ovr_i | input | 1 | Width override present (adds one setup cycle) |
| wide_i | input | 1 | 1 = 24-bit addressing, 0 = 16-bit addressing |
| cnt_i | input | 8 | Initial byte counter |
| port_i | input | 8 | Initial port pointer |
| ptr_i | input | 24 | Initial memory pointer |
| base_i | input | 8 | Upper memory address byte for 16-bit mode |
| io_rd_o | output | 1 | I/O read strobe |
| io_addr_o | output | 16 | I/O address |
| io_data_i | input | 8 | I/O read data |
| mem_wr_o | output | 1 | Memory write strobe |
| mem_addr_o | output | 24 | Memory write address |
| mem_data_o | output | 8 | Memory write data |
| cnt_o | output | 8 | Current byte counter |
| port_o | output | 8 | Current port pointer |
| ptr_o | output | 24 | Current memory pointer |
| z_o | output | 1 | Zero flag |
| n_o | output | 1 | Data bit-7 flag |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Some rules are checked on every cycle. These include the read-write-update ordering and the exclusion of the two strobes. They also include the one-step changes of counter, flags and pointer after each update, the frozen upper pointer byte in 16-bit mode, and the tie between the falling busy and the done pulse. Other behaviour needs the bench's scenarios, with expected values computed independently. That covers the address and data on every strobe, the byte totals for single, repeat and zero-count starts, and the exact busy lengths with and without the override. It also covers wrap-around of port and pointer in both addressing widths, and the proof that a start while busy changes nothing.

// File: rtl/blkin_pkg.sv
package blkin_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETUP,
      ST_RD,
      ST_WR,
      ST_UPD
   } blkin_st_e;
endpackage

// File: rtl/blkin_seq.sv
module blkin_seq
   import blkin_pkg::*;
#(
   parameter int SETUP_CYC = 2,
   parameter int OVR_EXTRA = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic repeat_i,
   input  logic ovr_i,
   input  logic cnt_one_i,
   output logic accept_o,
   output logic rd_o,
   output logic wr_o,
   output logic upd_o,
   output logic busy_o,
   output logic done_o
);
   localparam int SETUP_MAX = SETUP_CYC + OVR_EXTRA;
   localparam int SC_W      = $clog2(SETUP_MAX + 1);

   generate
      if (SETUP_CYC < 1) begin : g_bad_setup
         $error("blkin_seq: SETUP_CYC must be at least 1");
      end
      if (OVR_EXTRA < 0) begin : g_bad_ovr
         $error("blkin_seq: OVR_EXTRA must not be negative");
      end
   endgenerate

   blkin_st_e      st_q;
   logic [SC_W-1:0] setup_q;
   logic           rep_q;
   logic           done_q;

   assign accept_o = (st_q == ST_IDLE) && start_i;
   assign rd_o     = (st_q == ST_RD);
   assign wr_o     = (st_q == ST_WR);
   assign upd_o    = (st_q == ST_UPD);
   assign busy_o   = (st_q != ST_IDLE);
   assign done_o   = done_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         setup_q <= '0;
         rep_q   <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (start_i) begin
                  st_q    <= ST_SETUP;
                  rep_q   <= repeat_i;
                  setup_q <= ovr_i ? SC_W'(SETUP_MAX - 1) : SC_W'(SETUP_CYC - 1);
               end
            end
            ST_SETUP: begin
               if (setup_q == '0) st_q <= ST_RD;
               else               setup_q <= setup_q - 1'b1;
            end
            ST_RD:  st_q <= ST_WR;
            ST_WR:  st_q <= ST_UPD;
            ST_UPD: begin
               if (rep_q && !cnt_one_i) begin
                  st_q <= ST_RD;
               end else begin
                  st_q   <= ST_IDLE;
                  done_q <= 1'b1;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   // R2
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rd_o, wr_o, upd_o}));
   // R2
   rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_o |=> wr_o);
   // R2
   wr_then_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_o |=> upd_o);
   // R10
   done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> done_o);
   // R10
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);
endmodule

// File: rtl/blkin_cnt.sv
module blkin_cnt #(
   parameter int CNT_W  = 8,
   parameter int PORT_W = 8,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              cap_i,
   input  logic              upd_i,
   input  logic [CNT_W-1:0]  cnt_i,
   input  logic [PORT_W-1:0] port_i,
   input  logic [DATA_W-1:0] data_i,
   output logic [CNT_W-1:0]  cnt_o,
   output logic [PORT_W-1:0] port_o,
   output logic [DATA_W-1:0] data_o,
   output logic              z_o,
   output logic              n_o,
   output logic              cnt_one_o
);
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   generate
      if (CNT_W < 1 || PORT_W < 1 || DATA_W < 1) begin : g_bad_w
         $error("blkin_cnt: widths must be positive");
      end
   endgenerate

   logic [CNT_W-1:0]  cnt_q;
   logic [PORT_W-1:0] port_q;
   logic [DATA_W-1:0] data_q;
   logic              z_q, n_q;

   assign cnt_one_o = (cnt_q == CNT_ONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         port_q <= '0;
         data_q <= '0;
         z_q    <= 1'b0;
         n_q    <= 1'b0;
      end else if (load_i) begin
         cnt_q  <= cnt_i;
         port_q <= port_i;
      end else begin
         if (cap_i) data_q <= data_i;
         if (upd_i) begin
            cnt_q  <= cnt_q - 1'b1;
            port_q <= port_q + 1'b1;
            z_q    <= (cnt_q == CNT_ONE);
            n_q    <= data_q[DATA_W-1];
         end
      end
   end

   assign cnt_o  = cnt_q;
   assign port_o = port_q;
   assign data_o = data_q;
   assign z_o    = z_q;
   assign n_o    = n_q;

   // R3
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd_i |=> (cnt_o == $past(cnt_o) - 1'b1) && (port_o == $past(port_o) + 1'b1));
   // R4
   z_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd_i |=> (z_o == ($past(cnt_o) == CNT_ONE)));
   // R5
   n_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd_i |=> (n_o == $past(data_o[DATA_W-1])));
   // R2
   data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_i && !load_i |=> $stable(data_o));
endmodule

// File: rtl/blkin_ptr.sv
module blkin_ptr #(
   parameter int ADDR_W  = 24,
   parameter int SHORT_W = 16
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      load_i,
   input  logic                      upd_i,
   input  logic                      wide_i,
   input  logic [ADDR_W-1:0]         ptr_i,
   input  logic [ADDR_W-SHORT_W-1:0] base_i,
   output logic [ADDR_W-1:0]         ptr_o,
   output logic [ADDR_W-1:0]         mem_addr_o
);
   localparam int HI_W = ADDR_W - SHORT_W;

   generate
      if (HI_W < 1) begin : g_bad_w
         $error("blkin_ptr: ADDR_W must exceed SHORT_W");
      end
   endgenerate

   logic [SHORT_W-1:0] lo_q;
   logic [HI_W-1:0]    hi_q;
   logic [HI_W-1:0]    base_q;
   logic               wide_q;
   logic               lo_wrap;

   assign lo_wrap = &lo_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_q   <= '0;
         base_q <= '0;
         wide_q <= 1'b1;
      end else if (load_i) begin
         lo_q   <= ptr_i[SHORT_W-1:0];
         base_q <= base_i;
         wide_q <= wide_i;
      end else if (upd_i) begin
         lo_q   <= lo_q + 1'b1;
      end
   end

   generate
      if (HI_W > 0) begin : g_hi
         always_ff @(posedge clk) begin
            if (!rst_n)                       hi_q <= '0;
            else if (load_i)                  hi_q <= ptr_i[ADDR_W-1:SHORT_W];
            else if (upd_i && wide_q && lo_wrap) hi_q <= hi_q + 1'b1;
         end
      end
   endgenerate

   assign ptr_o      = {hi_q, lo_q};
   assign mem_addr_o = wide_q ? {hi_q, lo_q} : {base_q, lo_q};

   // R9
   wide_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd_i && wide_q |=> ptr_o == $past(ptr_o) + 1'b1);
   // R8
   short_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd_i && !wide_q |=> $stable(ptr_o[ADDR_W-1:SHORT_W]));
   // R8
   short_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd_i && !wide_q |=> ptr_o[SHORT_W-1:0] == $past(ptr_o[SHORT_W-1:0]) + 1'b1);
endmodule

// File: rtl/blkin_engine.sv
module blkin_engine #(
   parameter int CNT_W     = 8,
   parameter int PORT_W    = 8,
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 24,
   parameter int SHORT_W   = 16,
   parameter int IO_ADDR_W = 16,
   parameter int SETUP_CYC = 2,
   parameter int OVR_EXTRA = 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start_i,
   input  logic                      repeat_i,
   input  logic                      ovr_i,
   input  logic                      wide_i,
   input  logic [CNT_W-1:0]          cnt_i,
   input  logic [PORT_W-1:0]         port_i,
   input  logic [ADDR_W-1:0]         ptr_i,
   input  logic [ADDR_W-SHORT_W-1:0] base_i,
   output logic                      io_rd_o,
   output logic [IO_ADDR_W-1:0]      io_addr_o,
   input  logic [DATA_W-1:0]         io_data_i,
   output logic                      mem_wr_o,
   output logic [ADDR_W-1:0]         mem_addr_o,
   output logic [DATA_W-1:0]         mem_data_o,
   output logic [CNT_W-1:0]          cnt_o,
   output logic [PORT_W-1:0]         port_o,
   output logic [ADDR_W-1:0]         ptr_o,
   output logic                      z_o,
   output logic                      n_o,
   output logic                      busy_o,
   output logic                      done_o
);
   localparam int PAD_W = IO_ADDR_W - PORT_W;

   generate
      if (PAD_W < 1) begin : g_bad_io
         $error("blkin_engine: IO_ADDR_W must exceed PORT_W");
      end
   endgenerate

   logic accept, upd, cnt_one;

   blkin_seq #(.SETUP_CYC(SETUP_CYC), .OVR_EXTRA(OVR_EXTRA)) u_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .repeat_i(repeat_i),
      .ovr_i(ovr_i), .cnt_one_i(cnt_one), .accept_o(accept), .rd_o(io_rd_o),
      .wr_o(mem_wr_o), .upd_o(upd), .busy_o(busy_o), .done_o(done_o)
   );

   blkin_cnt #(.CNT_W(CNT_W), .PORT_W(PORT_W), .DATA_W(DATA_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .load_i(accept), .cap_i(io_rd_o), .upd_i(upd),
      .cnt_i(cnt_i), .port_i(port_i), .data_i(io_data_i), .cnt_o(cnt_o),
      .port_o(port_o), .data_o(mem_data_o), .z_o(z_o), .n_o(n_o),
      .cnt_one_o(cnt_one)
   );

   blkin_ptr #(.ADDR_W(ADDR_W), .SHORT_W(SHORT_W)) u_ptr (
      .clk(clk), .rst_n(rst_n), .load_i(accept), .upd_i(upd), .wide_i(wide_i),
      .ptr_i(ptr_i), .base_i(base_i), .ptr_o(ptr_o), .mem_addr_o(mem_addr_o)
   );

   assign io_addr_o = {{PAD_W{1'b0}}, port_o};

   // R1
   io_hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      io_rd_o |-> io_addr_o[IO_ADDR_W-1:PORT_W] == '0);
   // R2
   wr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_o |=> $stable(mem_addr_o));
endmodule

// File: tb/tb_blkin_engine.sv
module tb_blkin_engine;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0, repeat_i = 1'b0, ovr_i = 1'b0, wide_i = 1'b1;
   logic [7:0]  cnt_i = '0, port_i = '0, base_i = '0;
   logic [23:0] ptr_i = '0;
   logic        io_rd_o, mem_wr_o, z_o, n_o, busy_o, done_o;
   logic [15:0] io_addr_o;
   logic [7:0]  io_data_i, mem_data_o, cnt_o, port_o;
   logic [23:0] mem_addr_o, ptr_o;
   logic [7:0]  salt = 8'h00;

   int checks = 0;
   int errors = 0;
   int cyc_total = 0;

   always #2.5 clk = ~clk;

   blkin_engine dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .repeat_i(repeat_i),
      .ovr_i(ovr_i), .wide_i(wide_i), .cnt_i(cnt_i), .port_i(port_i),
      .ptr_i(ptr_i), .base_i(base_i), .io_rd_o(io_rd_o), .io_addr_o(io_addr_o),
      .io_data_i(io_data_i), .mem_wr_o(mem_wr_o), .mem_addr_o(mem_addr_o),
      .mem_data_o(mem_data_o), .cnt_o(cnt_o), .port_o(port_o), .ptr_o(ptr_o),
      .z_o(z_o), .n_o(n_o), .busy_o(busy_o), .done_o(done_o)
   );

   function automatic logic [7:0] pat(input logic [7:0] a, input logic [7:0] s);
      return (a * 8'd53) ^ s;
   endfunction

   function automatic logic [23:0] ptr_at(input logic [23:0] p, input int k, input logic w);
      logic [23:0] r;
      if (w) r = p + 24'(k);
      else   r = {p[23:16], p[15:0] + 16'(k)};
      return r;
   endfunction

   assign io_data_i = pat(io_addr_o[7:0], salt);

   task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc_total++;
      if (cyc_total > 150000) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=<150000", cyc_total);
         $display("Result: errors=%0d of %0d checks", errors, checks + 1);
         $finish;
      end
   end

   task automatic run(input logic [7:0] b, input logic [7:0] c, input logic [23:0] hl,
                      input logic [7:0] base, input logic rep, input logic ovr,
                      input logic w, input logic poke);
      int n, cyc, k, exp_cyc;
      logic [7:0] last_d;
      n = rep ? ((b == 0) ? 256 : int'(b)) : 1;
      exp_cyc = 2 + (ovr ? 1 : 0) + 3 * n;
      @(negedge clk);
      start_i = 1'b1; repeat_i = rep; ovr_i = ovr; wide_i = w;
      cnt_i = b; port_i = c; ptr_i = hl; base_i = base;
      @(negedge clk);
      start_i = 1'b0;
      cyc = 0; k = 0; last_d = '0;
      while (busy_o && cyc < 2000) begin
         cyc++;
         if (poke) begin
            start_i = (cyc == 4);
            repeat_i = ~rep; ovr_i = ~ovr; wide_i = ~w;
            cnt_i = 8'h5A; port_i = 8'h33; ptr_i = 24'h123456;
         end
         if (io_rd_o) begin
            // R1
            chk(io_addr_o == {8'h00, c + 8'(k)}, "R1 io_addr", io_addr_o, {8'h00, c + 8'(k)});
            // R2
            chk(!mem_wr_o, "R2 strobe overlap", mem_wr_o, 0);
         end
         if (mem_wr_o) begin
            logic [23:0] pk, ea;
            pk = ptr_at(hl, k, w);
            ea = w ? pk : {base, pk[15:0]};
            last_d = pat(c + 8'(k), salt);
            // R8 / R9 address, R2 data
            chk(mem_addr_o == ea, w ? "R9 mem_addr" : "R8 mem_addr", mem_addr_o, ea);
            chk(mem_data_o == last_d, "R2 mem_data", mem_data_o, last_d);
            k++;
         end
         @(negedge clk);
      end
      start_i = 1'b0;
      // R7
      chk(cyc == exp_cyc, "R7 busy length", cyc, exp_cyc);
      // R6
      chk(k == n, "R6 byte count", k, n);
      // R10
      chk(done_o == 1'b1, "R10 done pulse", done_o, 1);
      // R3
      chk(cnt_o == b - 8'(n), "R3 counter", cnt_o, b - 8'(n));
      chk(port_o == c + 8'(n), "R3 port", port_o, c + 8'(n));
      chk(ptr_o == ptr_at(hl, n, w), w ? "R9 pointer" : "R8 pointer", ptr_o, ptr_at(hl, n, w));
      // R4
      chk(z_o == (cnt_o == 8'h00), "R4 zero flag", z_o, (b - 8'(n)) == 8'h00);
      // R5
      chk(n_o == last_d[7], "R5 n flag", n_o, last_d[7]);
      @(negedge clk);
      // R10
      chk(done_o == 1'b0, "R10 done width", done_o, 0);
   endtask

   initial begin
      int unsigned seed;
      seed = $urandom(32'd2718);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11
      chk(!busy_o && !done_o && !io_rd_o && !mem_wr_o && !z_o && !n_o, "R11 reset state",
          {busy_o, done_o, io_rd_o, mem_wr_o, z_o, n_o}, 0);

      // directed corner cases
      salt = 8'h00; run(8'd1, 8'h10, 24'h000100, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0); // R4 z=1 single
      salt = 8'h80; run(8'd3, 8'h20, 24'h000200, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0); // R6 single, R7 ovr
      run(8'd0, 8'h05, 24'h001000, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0);               // R6 single B=0
      salt = 8'h3C; run(8'd0, 8'hF0, 24'hFFFF80, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0); // R6 256, R9 wrap
      run(8'd6, 8'hFD, 24'h7AFFFD, 8'h44, 1'b1, 1'b1, 1'b0, 1'b0);               // R8 short wrap
      run(8'd5, 8'h40, 24'h00ABCD, 8'h12, 1'b1, 1'b0, 1'b1, 1'b1);               // R10 start while busy
      run(8'd1, 8'hFF, 24'hFFFFFF, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0);               // R9 wrap to 0

      // constrained random
      for (int i = 0; i < 40; i++) begin
         logic [7:0] rb;
         logic       rr;
         rr = 1'($urandom);
         rb = rr ? 8'(1 + ($urandom % 20)) : 8'($urandom);
         salt = 8'($urandom);
         run(rb, 8'($urandom), 24'($urandom), 8'($urandom), rr, 1'($urandom),
             1'($urandom), 1'($urandom % 4 == 0));
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule